// File: doc/BRIEF.md
# Posted-Write Queue with Read-Miss Bypass

This block sits between a data cache and the next memory level. Stores, whether single words from a write-through cache or dirty lines evicted by a write-back cache, are posted into a small queue. The producer moves on at once, and the queue retires the stores to memory oldest first over one shared request port.

A read miss does not have to wait behind the posted stores. Its address is first compared with every occupied queue slot. If any slot holds that address, the block answers the read itself with the data of the most recently posted matching store, and memory is not touched. If no slot matches, the read goes to memory ahead of the queued stores. This is safe because memory already holds the newest value of that address. A configuration input selects a simpler conservative mode instead, in which a read miss is held off until the queue has drained completely.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset, wr_ready and rd_ready are 1, and mem_req_valid and rsp_valid are 0.
- R2: wr_ready is 1 while fewer than DEPTH slots are occupied and 0 while all DEPTH slots are occupied. A store handshake (wr_valid and wr_ready both 1 at a clock edge) occupies one slot.
- R3: Posted stores reach memory (mem_req_valid=1, mem_req_we=1, accepted by mem_req_ready) in exactly the order they were posted, carrying the same address and data.
- R4: A read whose address matches no occupied slot issues one memory read (mem_req_we=0) and returns mem_rsp_data on rsp_data. The occupied slots stay untouched while it does so.
- R5: A read whose address matches an occupied slot is answered on the cycle after the read handshake, with rsp_valid=1, and issues no memory read. Slots filled by a store handshake in the same cycle as the read handshake take no part in the match.
- R6: When several occupied slots match, the answer carries the data of the most recently posted of them.
- R7: With strict_order=1, rd_ready stays 0 while any slot is occupied, so every posted store has been sent to memory before the read is accepted.
- R8: In the cycle of a read handshake no store is sent to memory, and a missing read is the next memory request after that handshake.
- R9: At most one memory read is outstanding at a time. mem_req_valid stays 0 from the acceptance of a memory read until its mem_rsp_valid.
- R10: Every read returns the value of the latest store to its address posted before the read handshake (or the prior memory content), and once the queue is drained memory equals the program-order result of all stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_order | input | 1 | 1: read misses wait for an empty queue |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Queue can accept a store |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Read-miss request |
| rd_ready | output | 1 | Read-miss request accepted |
| rd_addr | input | AW | Read-miss address |
| rsp_valid | output | 1 | One-cycle read answer strobe |
| rsp_data | output | DW | Read answer data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1: store, 0: read |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory store data |
| mem_rsp_valid | input | 1 | Memory read data strobe |
| mem_rsp_data | input | DW | Memory read data |

## Verification
The bound checker keeps its own slot count from the handshakes. On every cycle it checks that the ready flag follows that count, that strict mode accepts reads only on an empty queue, that no store leaves in a read-handshake cycle, and that no request appears while a memory read is outstanding. Store ordering, youngest-match forwarding, the one-cycle forwarding latency and the final agreement of memory with a golden image depend on data values. Only the bench scenarios can show these: a full-queue sequence with repeated addresses, a strict-mode run, and a sweep with throttled memory readiness.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ISSUE = 2'd1,
        RS_WAIT  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
// Circular slot storage: push at tail, pop at head. DEPTH must be a power of two (>= 2).
module wbuf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [AW-1:0]                push_addr,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DEPTH-1:0]             ent_vld,
    output logic [DEPTH-1:0][AW-1:0]     ent_addr,
    output logic [DEPTH-1:0][DW-1:0]     ent_data,
    output logic [$clog2(DEPTH)-1:0]     head,
    output logic                         empty,
    output logic                         full
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pop) begin
            s_d.vld[s_q.head] = 1'b0;
            s_d.head          = s_q.head + 1'b1;
        end
        if (push) begin
            s_d.vld[s_q.tail]  = 1'b1;
            s_d.addr[s_q.tail] = push_addr;
            s_d.data[s_q.tail] = push_data;
            s_d.tail           = s_q.tail + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ent_vld  = s_q.vld;
    assign ent_addr = s_q.addr;
    assign ent_data = s_q.data;
    assign head     = s_q.head;
    assign empty    = ~|s_q.vld;
    assign full     = &s_q.vld;
endmodule

// File: rtl/wbuf_match.sv
// Associative lookup: walks slots from oldest to youngest so the youngest hit wins.
module wbuf_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16
) (
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0][AW-1:0]     ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]     ent_data,
    input  logic [$clog2(DEPTH)-1:0]     head,
    input  logic [AW-1:0]                key,
    output logic                         hit,
    output logic [DW-1:0]                hit_data
);
    localparam int PW = $clog2(DEPTH);

    logic [DEPTH-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign eq[g] = ent_vld[g] && (ent_addr[g] == key);
        end
    endgenerate

    always_comb begin
        logic [PW-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (eq[idx]) begin
                hit      = 1'b1;
                hit_data = ent_data[idx];
            end
        end
    end
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strict_order,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        rd_state_e     st;
        logic [AW-1:0] raddr;
        logic          rsp_v;
        logic [DW-1:0] rsp_d;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [DEPTH-1:0]         e_vld;
    logic [DEPTH-1:0][AW-1:0] e_addr;
    logic [DEPTH-1:0][DW-1:0] e_data;
    logic [PW-1:0]            head;
    logic                     empty, full, push, pop;
    logic                     hit, rd_take, drain;
    logic [DW-1:0]            hit_data;

    wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_addr(wr_addr),
        .push_data(wr_data),
        .pop      (pop),
        .ent_vld  (e_vld),
        .ent_addr (e_addr),
        .ent_data (e_data),
        .head     (head),
        .empty    (empty),
        .full     (full)
    );

    wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ent_vld (e_vld),
        .ent_addr(e_addr),
        .ent_data(e_data),
        .head    (head),
        .key     (rd_addr),
        .hit     (hit),
        .hit_data(hit_data)
    );

    always_comb begin
        wr_ready      = !full;
        push          = wr_valid && !full;
        rd_ready      = (c_q.st == RS_IDLE) && (!strict_order || empty);
        rd_take       = rd_valid && rd_ready;
        // a read handshake blocks draining for that cycle: reads go first
        drain         = (c_q.st == RS_IDLE) && !empty && !rd_take;
        mem_req_valid = drain || (c_q.st == RS_ISSUE);
        mem_req_we    = drain;
        mem_req_addr  = (c_q.st == RS_ISSUE) ? c_q.raddr : e_addr[head];
        mem_req_wdata = e_data[head];
        pop           = drain && mem_req_ready;

        c_d       = c_q;
        c_d.rsp_v = 1'b0;
        unique case (c_q.st)
            RS_IDLE: begin
                if (rd_take) begin
                    if (hit) begin
                        c_d.rsp_v = 1'b1;
                        c_d.rsp_d = hit_data;
                    end else begin
                        c_d.st    = RS_ISSUE;
                        c_d.raddr = rd_addr;
                    end
                end
            end
            RS_ISSUE: begin
                if (mem_req_ready) c_d.st = RS_WAIT;
            end
            RS_WAIT: begin
                if (mem_rsp_valid) begin
                    c_d.st    = RS_IDLE;
                    c_d.rsp_v = 1'b1;
                    c_d.rsp_d = mem_rsp_data;
                end
            end
            default: c_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rsp_valid = c_q.rsp_v;
    assign rsp_data  = c_q.rsp_d;
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
    parameter int DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic strict_order,
    input logic wr_valid,
    input logic wr_ready,
    input logic rd_valid,
    input logic rd_ready,
    input logic mem_req_valid,
    input logic mem_req_ready,
    input logic mem_req_we,
    input logic mem_rsp_valid
);
    localparam int CW = $clog2(DEPTH + 1) + 1;

    logic [CW-1:0] occ_q;
    logic          inflight_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q      <= '0;
            inflight_q <= 1'b0;
        end else begin
            occ_q <= occ_q
                   + CW'(wr_valid && wr_ready)
                   - CW'(mem_req_valid && mem_req_ready && mem_req_we);
            if (mem_req_valid && mem_req_ready && !mem_req_we) inflight_q <= 1'b1;
            else if (mem_rsp_valid)                             inflight_q <= 1'b0;
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CW'(DEPTH));

    p_ready_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready == (occ_q < CW'(DEPTH)));

    p_drain_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (occ_q != '0));

    p_strict_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_order && rd_valid && rd_ready) |-> (occ_q == '0));

    p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |-> !(mem_req_valid && mem_req_we));

    p_one_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> !mem_req_valid);
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .strict_order (strict_order),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_we   (mem_req_we),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/sim_wbuf_bypass.sv
`timescale 1ns/1ps
module sim_wbuf_bypass;
    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strict_order = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid = 1'b0;
    logic          rd_ready;
    logic [AW-1:0] rd_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic          mem_req_we;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    wbuf_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int nwr = 0, nrd = 0, nacc = 0, nenq = 0;
    int take_nacc = 0;
    logic gate = 1'b1;
    logic auto_gate = 1'b0;
    logic acc_we [4096];
    logic [DW-1:0] mem  [256];
    logic [DW-1:0] gold [256];
    logic [AW-1:0] eq_a [$];
    logic [DW-1:0] eq_d [$];
    logic          rv1 = 1'b0;
    logic [AW-1:0] ra1 = '0;

    assign mem_req_ready = mem_req_we ? (auto_gate ? ((cyc % 3) != 0) : gate) : 1'b1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            mem[a]  = DW'(a * 37 + 11);
            gold[a] = DW'(a * 37 + 11);
        end
    end

    // memory model and store-order monitor (R3)
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
        mem_rsp_valid <= rv1;
        mem_rsp_data  <= mem[ra1];
        rv1 <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            acc_we[nacc] = mem_req_we;
            nacc++;
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                nwr++;
                if (eq_a.size() == 0) begin
                    chk(0, "R3", "store with empty expectation", mem_req_addr, -1);
                end else begin
                    chk(eq_a[0] == mem_req_addr && eq_d[0] == mem_req_wdata, "R3",
                        "store order addr/data", {mem_req_addr, mem_req_wdata},
                        {eq_a[0], eq_d[0]});
                    void'(eq_a.pop_front());
                    void'(eq_d.pop_front());
                end
            end else begin
                nrd++;
                rv1 <= 1'b1;
                ra1 <= mem_req_addr;
            end
        end
    end

    // called at a negedge, returns at a negedge
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        gold[a] = d;
        eq_a.push_back(a);
        eq_d.push_back(d);
        nenq++;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string rq);
        logic [DW-1:0] expv;
        bit fwd;
        int rd0;
        int w;
        rd_valid = 1'b1; rd_addr = a;
        while (!rd_ready) @(negedge clk);
        expv = gold[a];
        fwd  = 1'b0;
        foreach (eq_a[i]) if (eq_a[i] == a) fwd = 1'b1;
        rd0 = nrd;
        take_nacc = nacc;
        if (strict_order) chk(nwr == nenq, "R7", "stores sent before strict read", nwr, nenq);
        @(negedge clk);
        rd_valid = 1'b0;
        if (fwd) begin
            chk(rsp_valid == 1'b1, "R5", "forward answer next cycle", rsp_valid, 1);
            chk(rsp_data == expv, rq, "forwarded data", rsp_data, expv);
            chk(nrd == rd0, "R5", "no memory read on hit", nrd, rd0);
            @(negedge clk);
        end else begin
            w = 0;
            while (!rsp_valid && w < 40) begin @(negedge clk); w++; end
            chk(rsp_valid == 1'b1, "R4", "miss answered", rsp_valid, 1);
            chk(rsp_data == expv, rq, "miss data", rsp_data, expv);
            chk(nrd == rd0 + 1, "R4", "one memory read on miss", nrd, rd0 + 1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
        chk(rd_ready == 1'b1, "R1", "rd_ready after reset", rd_ready, 1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

        // fill the queue with memory refusing stores (R2), repeated address 5
        gate = 1'b0;
        do_write(8'd5, 16'd100);
        do_write(8'd6, 16'd200);
        do_write(8'd5, 16'd300);
        chk(wr_ready == 1'b1, "R2", "ready with three slots used", wr_ready, 1);
        do_write(8'd7, 16'd400);
        chk(wr_ready == 1'b0, "R2", "not ready when full", wr_ready, 0);
        repeat (3) @(negedge clk);
        chk(wr_ready == 1'b0, "R2", "stays full without draining", wr_ready, 0);

        do_read(8'd5, "R6");   // youngest of two matches: 300
        do_read(8'd6, "R5");
        do_read(8'd9, "R4");   // bypass while queue is full
        chk(wr_ready == 1'b0, "R4", "queue untouched by bypass", wr_ready, 0);
        chk(nwr == 0, "R4", "no store sent during bypass", nwr, 0);

        gate = 1'b1;
        repeat (8) @(negedge clk);
        chk(eq_a.size() == 0, "R3", "all stores drained", eq_a.size(), 0);
        do_read(8'd5, "R10");  // now from memory

        // read priority over pending stores (R8)
        gate = 1'b0;
        do_write(8'd20, 16'd1234);
        do_write(8'd21, 16'd2345);
        gate = 1'b1;
        do_read(8'd50, "R8");
        chk(acc_we[take_nacc] == 1'b0, "R8", "read issued before stores", acc_we[take_nacc], 0);
        repeat (6) @(negedge clk);

        // strict mode (R7)
        strict_order = 1'b1;
        gate = 1'b0;
        do_write(8'd30, 16'd777);
        do_write(8'd31, 16'd888);
        chk(rd_ready == 1'b0, "R7", "read held while queue occupied", rd_ready, 0);
        gate = 1'b1;
        do_read(8'd30, "R7");
        strict_order = 1'b0;

        // sweep with throttled store acceptance
        auto_gate = 1'b1;
        for (int i = 0; i < 90; i++) begin
            do_write(AW'((i * 5) % 8), DW'(i * 97 + 3));
            if ((i % 3) == 2) do_read(AW'((i * 3) % 8), "R10");
        end
        auto_gate = 1'b0;
        gate = 1'b1;
        repeat (20) @(negedge clk);
        chk(eq_a.size() == 0, "R3", "sweep stores all drained", eq_a.size(), 0);
        begin
            int mism = 0;
            for (int a = 0; a < 256; a++) if (mem[a] !== gold[a]) mism++;
            chk(mism == 0, "R10", "memory image mismatches", mism, 0);
        end
        finish_run();
    end
endmodule